// File: doc/BRIEF.md
# Free-Running Timer with Prescaler

A 16-bit up-counter that runs continuously for a microcontroller peripheral. Software reaches it over a small synchronous 8-bit register port with an address, write data, a write strobe, a read strobe and combinational read data. The count advances on a selectable tick. The tick is the core clock divided by 2, 4 or 8, or an active edge of an external clock input. The external input is resynchronised and edge-detected in the core clock domain, and it must toggle at most once every four core cycles.

The count has two read views that return the same value. Each view is split into a high byte and a low byte. Reading either high byte captures the low byte into a buffer, so a high-then-low read pair always gives one coherent 16-bit value. The counter starts from FFFCh, and FFFCh is the only value ever loaded into it: a write to any of the four count bytes reloads FFFCh, whatever the data. When the count wraps from FFFFh to 0000h, an overflow flag is set. That flag drives an interrupt request through an enable bit. Software clears the flag with a status read followed by a low-byte read of the main view. A low-byte read of the alternate view never clears it.

Top module: `frt_timer`

Register map (3-bit address): 0 = control (read/write), 1 = status (read-only), 2 = main count high byte, 3 = main count low byte, 4 = alternate count high byte, 5 = alternate count low byte. Addresses 6 and 7 read as 00h.

## Requirements
- R1: After reset the count is FFFCh, the control byte reads 00h, the status byte reads 00h and irq is 0.
- R2: With control bits [1:0] = 00, 01 or 10, the count advances once every 2, 4 or 8 core cycles. The prescaler restarts from zero whenever the count is reloaded.
- R3: With control bits [1:0] = 11, the count advances once per active edge of ext_clk. Control bit 2 selects the edge: 1 = rising, 0 = falling. The count changes on the third rising core clock edge after ext_clk changes.
- R4: A write to address 2, 3, 4 or 5 reloads FFFCh, whatever the data, and takes priority over a tick in the same cycle.
- R5: Addresses 2/3 and addresses 4/5 return the same count, high byte and low byte respectively.
- R6: A tick at count FFFFh wraps the count to 0000h and sets status bit 7 (the overflow flag).
- R7: irq equals the overflow flag ANDed with control bit 7.
- R8: A read of address 2 or 4 captures the low byte of the count. The next read of address 3 or 5 returns the captured byte. A low-byte read with no capture pending returns the live low byte.
- R9: A status read while the flag is set, followed by a read of address 3, clears the flag. A read of address 5 never clears it.
- R10: If a wrap occurs after the status read and before the address-3 read, the flag stays set.
- R11: The control byte reads back bits 7, 2, 1 and 0 as written, and reads 0 in bits 6 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; side effects take place at the clock edge |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| ext_clk | input | 1 | External tick source, asynchronous |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest case is an overflow that lands between the status read and the main low-byte read. A natural wrap needs 65,536 ticks. The stimulus instead uses the reload-on-write rule to put the count at FFFCh, so at divide-by-2 the wrap follows eight cycles later. It arms the clear with a status read, reloads, waits for the second wrap, and only then issues the low-byte read. A behavioural reference model tracks the prescaler phase, the external-clock synchroniser stages, the capture buffer and the clear sequence. Every read and the interrupt line are compared against it on every cycle, including the per-cycle reads taken while ext_clk toggles.

// File: rtl/frt_pkg.sv
package frt_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int ADDR_W = 3;
    localparam int PS_W   = 3;
    localparam int SYNC_N = 3;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] RELOAD  = CNT_MAX - CNT_W'(3);

    typedef enum logic [1:0] {
        CK_DIV2 = 2'd0,
        CK_DIV4 = 2'd1,
        CK_DIV8 = 2'd2,
        CK_EXT  = 2'd3
    } clk_sel_e;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_STAT   = 3'd1,
        A_CNT_HI = 3'd2,
        A_CNT_LO = 3'd3,
        A_ALT_HI = 3'd4,
        A_ALT_LO = 3'd5
    } addr_e;

    typedef struct packed {
        logic     irq_en;
        logic     rise_edge;
        clk_sel_e sel;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{irq_en: 1'b0, rise_edge: 1'b0, sel: CK_DIV2};

    function automatic logic [PS_W-1:0] div_mask(input clk_sel_e s);
        case (s)
            CK_DIV2: div_mask = PS_W'(1);
            CK_DIV4: div_mask = PS_W'(3);
            default: div_mask = PS_W'(7);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_byte(input ctrl_t c);
        ctrl_to_byte = {c.irq_en, 4'b0000, c.rise_edge, c.sel};
    endfunction

    function automatic ctrl_t byte_to_ctrl(input logic [DATA_W-1:0] b);
        ctrl_t c;
        c.irq_en    = b[7];
        c.rise_edge = b[2];
        c.sel       = clk_sel_e'(b[1:0]);
        byte_to_ctrl = c;
    endfunction

    function automatic logic is_count_addr(input logic [ADDR_W-1:0] a);
        is_count_addr = (a == A_CNT_HI) || (a == A_CNT_LO) ||
                        (a == A_ALT_HI) || (a == A_ALT_LO);
    endfunction

endpackage

// File: rtl/frt_tick_gen.sv
module frt_tick_gen
    import frt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_e sel,
    input  logic     rise_edge,
    input  logic     restart,
    input  logic     ext_clk,
    output logic     tick
);

    logic [PS_W-1:0]   ps_q;
    logic [SYNC_N-1:0] sync_q;
    logic              int_tick;
    logic              ext_tick;
    logic              s_new;
    logic              s_old;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_q + PS_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], ext_clk};
        end
    end

    assign s_new    = sync_q[SYNC_N-2];
    assign s_old    = sync_q[SYNC_N-1];
    assign int_tick = ((ps_q & div_mask(sel)) == div_mask(sel));
    assign ext_tick = rise_edge ? (s_new && !s_old) : (!s_new && s_old);

    always_comb begin
        if (sel == CK_EXT) begin
            tick = ext_tick;
        end else begin
            tick = int_tick;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && sel != CK_EXT) |=> (!tick || sel == CK_EXT)); // R2

endmodule

// File: rtl/frt_counter.sv
module frt_counter
    import frt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    assign wrap = tick && !load && (count == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            count <= RELOAD;
        end else if (tick) begin
            count <= count + CNT_W'(1);
        end
    end

    AST_RESET_VALUE: assert property (@(posedge clk)
        rst |=> (count == RELOAD)); // R1

    AST_WRITE_RELOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == RELOAD)); // R4

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(count)); // R2

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (count == '0)); // R6

endmodule

// File: rtl/frt_regs.sv
module frt_regs
    import frt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [CNT_W-1:0]  count,
    input  logic              wrap,
    output ctrl_t             ctrl,
    output logic              cnt_load,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    logic              ovf_flag;
    logic              clr_armed;
    logic              lo_valid;
    logic [DATA_W-1:0] lo_buf;
    logic              rd_stat;
    logic              rd_hi;
    logic              rd_lo;
    logic              rd_main_lo;
    logic [DATA_W-1:0] lo_view;

    assign rd_stat    = rd_en && (addr == A_STAT);
    assign rd_hi      = rd_en && ((addr == A_CNT_HI) || (addr == A_ALT_HI));
    assign rd_lo      = rd_en && ((addr == A_CNT_LO) || (addr == A_ALT_LO));
    assign rd_main_lo = rd_en && (addr == A_CNT_LO);
    assign cnt_load   = wr_en && is_count_addr(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_RST;
        end else if (wr_en && addr == A_CTRL) begin
            ctrl <= byte_to_ctrl(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag  <= 1'b0;
            clr_armed <= 1'b0;
        end else if (wrap) begin
            ovf_flag  <= 1'b1;
            clr_armed <= 1'b0;
        end else if (rd_main_lo && clr_armed) begin
            ovf_flag  <= 1'b0;
            clr_armed <= 1'b0;
        end else if (rd_stat && ovf_flag) begin
            clr_armed <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_buf   <= '0;
            lo_valid <= 1'b0;
        end else if (rd_hi) begin
            lo_buf   <= count[DATA_W-1:0];
            lo_valid <= 1'b1;
        end else if (rd_lo) begin
            lo_valid <= 1'b0;
        end
    end

    assign lo_view = lo_valid ? lo_buf : count[DATA_W-1:0];

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata = ctrl_to_byte(ctrl);
        end else if (addr == A_STAT) begin
            rdata = {ovf_flag, {(DATA_W-1){1'b0}}};
        end else if (addr == A_CNT_HI || addr == A_ALT_HI) begin
            rdata = count[CNT_W-1:DATA_W];
        end else if (addr == A_CNT_LO || addr == A_ALT_LO) begin
            rdata = lo_view;
        end
    end

    assign irq = ovf_flag && ctrl.irq_en;

    AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ovf_flag); // R6

    AST_ALT_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_ALT_LO && ovf_flag) |=> ovf_flag); // R9

    AST_CLEAR_NEEDS_LOW_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(ovf_flag) |-> $past(rd_en && addr == A_CNT_LO)); // R9

    AST_COHERENT_LOW: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en && addr == A_CNT_HI) && rd_en && addr == A_CNT_LO)
            |-> (rdata == $past(count[DATA_W-1:0]))); // R8

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> ovf_flag); // R7

endmodule

// File: rtl/frt_timer.sv
module frt_timer
    import frt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_clk,
    output logic              irq
);

    ctrl_t            ctrl;
    logic             tick;
    logic             cnt_load;
    logic             wrap;
    logic [CNT_W-1:0] count;

    frt_tick_gen u_tick (
        .clk       (clk),
        .rst       (rst),
        .sel       (ctrl.sel),
        .rise_edge (ctrl.rise_edge),
        .restart   (cnt_load),
        .ext_clk   (ext_clk),
        .tick      (tick)
    );

    frt_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .load  (cnt_load),
        .count (count),
        .wrap  (wrap)
    );

    frt_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .wr_en    (bus_wr),
        .rd_en    (bus_rd),
        .count    (count),
        .wrap     (wrap),
        .ctrl     (ctrl),
        .cnt_load (cnt_load),
        .rdata    (bus_rdata),
        .irq      (irq)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!irq && ctrl == CTRL_RST)); // R1

endmodule

// File: tb/frt_timer_test.sv
module frt_timer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       ext_clk = 1'b0;
    logic       irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string tag = "R1";

    // behavioural reference state
    int       m_cnt;
    int       m_phase;
    bit [7:0] m_ctrl;
    bit       m_flag, m_arm, m_bufv;
    bit [7:0] m_buf;
    bit       m_s1, m_s2, m_s3;

    always #2.5 clk = ~clk;

    frt_timer uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ext_clk(ext_clk), .irq(irq)
    );

    function automatic bit [7:0] exp_rd(input int a);
        case (a)
            0: exp_rd = m_ctrl;
            1: exp_rd = {m_flag, 7'b0};
            2, 4: exp_rd = 8'((m_cnt >> 8) & 255);
            3, 5: exp_rd = m_bufv ? m_buf : 8'(m_cnt & 255);
            default: exp_rd = 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 'hFFFC; m_phase = 0; m_ctrl = 8'h00;
            m_flag = 0; m_arm = 0; m_bufv = 0; m_buf = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            int  div;
            bit  tk, ld, wr_ok;
            div = 2 << m_ctrl[1:0];
            if (m_ctrl[1:0] == 2'b11)
                tk = m_ctrl[2] ? (m_s2 && !m_s3) : (!m_s2 && m_s3);
            else
                tk = ((m_phase % div) == div - 1);
            ld = bus_wr && bus_addr >= 2 && bus_addr <= 5;
            wr_ok = tk && !ld && m_cnt == 'hFFFF;
            if (bus_rd) begin
                if (bus_addr == 1 && m_flag) m_arm = 1;
                if (bus_addr == 2 || bus_addr == 4) begin
                    m_buf = 8'(m_cnt & 255); m_bufv = 1;
                end
                if (bus_addr == 3 || bus_addr == 5) m_bufv = 0;
                if (bus_addr == 3 && m_arm && !wr_ok) begin
                    m_flag = 0; m_arm = 0;
                end
            end
            if (wr_ok) begin m_flag = 1; m_arm = 0; end
            if (bus_wr && bus_addr == 0) m_ctrl = bus_wdata & 8'h87;
            if (ld) begin
                m_cnt = 'hFFFC; m_phase = 0;
            end else begin
                if (tk) m_cnt = (m_cnt + 1) & 'hFFFF;
                m_phase = m_phase + 1;
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
        end
    end

    always @(negedge clk) begin
        #1;
        if (!rst) begin
            n_cmp++;
            if (irq !== (m_flag && m_ctrl[7])) begin
                n_bad++;
                $display("FAIL R7 irq actual %0b expected %0b", irq, m_flag && m_ctrl[7]);
            end
            if (bus_rd) begin
                n_cmp++;
                if (bus_rdata !== exp_rd(bus_addr)) begin
                    n_bad++;
                    $display("FAIL %s read addr %0d actual %02h expected %02h",
                             tag, bus_addr, bus_rdata, exp_rd(bus_addr));
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic rd(input int a);
        @(negedge clk);
        bus_wr = 0; bus_rd = 1; bus_addr = 3'(a);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_rd = 0; bus_wr = 1; bus_addr = 3'(a); bus_wdata = 8'(d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_rd = 0; bus_wr = 0;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        // R1: reset state, read right after release
        tag = "R1";
        rd(0); rd(1); rd(2); rd(3); rd(4); rd(5);
        // R2: three prescaler ratios, R5 and R8 along the way
        tag = "R2";
        idle(5); rd(2); rd(3);
        wr(0, 8'h01); idle(9); rd(4); rd(5);
        wr(0, 8'h02); idle(17); rd(2); rd(3);
        // R4: any count write reloads, data ignored, prescaler restarts
        tag = "R4";
        wr(2, 8'h55); rd(2); rd(3);
        wr(5, 8'h00); idle(3); rd(4); rd(5);
        wr(3, 8'hAA); idle(7); rd(2); rd(3);
        // R5: both views agree
        tag = "R5";
        rd(2); rd(4); rd(3); rd(5);
        // R8: low byte captured by high read while counting at div2
        tag = "R8";
        wr(0, 8'h00); idle(3);
        rd(4); idle(3); rd(5); rd(3); rd(2); rd(5);
        // R6/R7: wrap sets flag, irq follows enable
        tag = "R6";
        wr(0, 8'h80); wr(3, 0); idle(12); rd(1); rd(2); rd(3);
        tag = "R7";
        wr(0, 8'h00); idle(3); wr(0, 8'h80); idle(3);
        // R9: alternate low read keeps flag, main low read clears
        tag = "R9";
        rd(1); rd(5); rd(1); rd(3); rd(1); idle(3);
        // R10: wrap between status read and low read keeps flag
        tag = "R10";
        wr(2, 0); idle(12); rd(1);
        wr(2, 0); idle(12); rd(3); rd(1); rd(3); rd(1); idle(2);
        // R3: external clock, rising then falling, read every cycle
        tag = "R3";
        wr(0, 8'h87); wr(2, 0);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            bus_wr = 0; bus_rd = 1; bus_addr = 3'd5;
            ext_clk = ((i % 8) >= 4);
        end
        wr(0, 8'h83); wr(2, 0);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            bus_wr = 0; bus_rd = 1; bus_addr = 3'd5;
            ext_clk = ((i % 10) >= 5);
        end
        rd(2); rd(3);
        // R11: control readback masks unused bits
        tag = "R11";
        wr(0, 8'hFF); rd(0); wr(0, 8'h7A); rd(0); wr(0, 8'h05); rd(0);
        idle(4);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule